// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block forms the full-width two's-complement product of two signed operands. It takes one step per clock and uses a single adder/subtractor that is shared across all the steps. An idle block accepts a request when `start_i` is high. In that cycle it registers both operands. It then runs exactly WIDTH steps. In each step, two bits decide what happens to the upper half of the product: the lowest bit of the multiplier still held in the register, and a guard bit to its right. The pair `10` subtracts the multiplicand, `01` adds it, and `00` or `11` leaves the upper half alone. The whole register then shifts right arithmetically by one place. The multiplier is consumed from the low half of the product register, so no separate multiplier register exists.

Signed operands need no correction step before or after the run. When the last step completes, the block pulses `done_o` for one cycle. From that cycle on, the high and low result words are presented on `hi_o` and `lo_o`. They stay there until the next request is accepted. A request made while a multiplication is in progress is ignored.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy_o` and `done_o` are 0, and `hi_o` and `lo_o` are all zeros.
- R2: When `start_i` is high at a rising edge and the block is idle, both operands are captured at that edge, and `busy_o` reads 1 in the cycle that follows.
- R3: Take `start_i` sampled at edge e0. After the run, `{hi_o, lo_o}` equals the 2·WIDTH-bit signed product of `mcand_i` and `mplier_i` as they stood at e0. `hi_o` holds the upper WIDTH bits. This holds for all operand values, including the most negative value on either or both inputs.
- R4: `done_o` is 1 for exactly one cycle, starting right after edge e0+WIDTH. In that same cycle `busy_o` has returned to 0.
- R5: A `start_i` sampled while `busy_o` is 1 has no effect. The running product is not altered, and no extra `done_o` pulse follows.
- R6: While the block is idle and `start_i` is low, `hi_o` and `lo_o` hold their values.
- R7: A step whose bit pair is `00` or `11` leaves the upper half unchanged apart from the arithmetic right shift. A multiplier of all zeros therefore gives a zero product, and a multiplier of all ones gives the negated multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a multiplication; honoured only when idle |
| mcand_i | input | WIDTH | Signed multiplicand, captured on the accepted start |
| mplier_i | input | WIDTH | Signed multiplier, captured on the accepted start |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| hi_o | output | WIDTH | Upper word of the product |
| lo_o | output | WIDTH | Lower word of the product |

## Verification
The bench drives every pair of small signed values from −8 to 7, sign-extended to the full width. These include 2×7 and 2×−3, and the all-zeros and all-ones multipliers. This set exposes an inverted recoding table and a logical shift used in place of an arithmetic one: either fault gives wrong signs or wrong magnitudes for negative multipliers. The bench also multiplies the most negative value by itself, by 1 and by −1. An adder that kept only WIDTH bits would lose the sign on those subtractions and return a wrong upper word. Stray starts are issued in mid-run, so a design that reloaded on them would report the wrong product or an extra done pulse. Each done pulse is timed from its accepted start, which catches a step counter that is off by one.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

    // Radix-2 recoding of (current multiplier bit, guard bit on its right).
    function automatic booth_op_e recode(input logic cur_bit, input logic right_bit);
        booth_op_e op;
        case ({cur_bit, right_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  booth_op_e        op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH:0]   sum_o
);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] acc_ext;
    logic [EW-1:0] mcand_ext;

    // One extra sign bit keeps the result exact even for the most negative multiplicand.
    assign acc_ext   = {acc_i[WIDTH-1], acc_i};
    assign mcand_ext = {mcand_i[WIDTH-1], mcand_i};

    always_comb begin
        case (op_i)
            OP_ADD:  sum_o = acc_ext + mcand_ext;
            OP_SUB:  sum_o = acc_ext - mcand_ext;
            default: sum_o = acc_ext;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    booth_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic          last_step;

    assign accept_o  = start_i && (state_q == ST_IDLE);
    assign step_o    = (state_q == ST_RUN);
    assign busy_o    = step_o;
    assign last_step = step_o && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= last_step;
            if (accept_o) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (last_step) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (step_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R4

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_q <= LAST)); // R4

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    typedef struct packed {
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic             guard;
    } prod_t;

    prod_t            prod_q;
    prod_t            prod_next;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH:0]   sum;
    logic             accept;
    logic             step;
    booth_op_e        op;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    assign op = recode(prod_q.lo[0], prod_q.guard);

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_i    (op),
        .acc_i   (prod_q.hi),
        .mcand_i (mcand_q),
        .sum_o   (sum)
    );

    // Arithmetic right shift of {sum, lo, guard}; the widened sum's top bit is the sign.
    always_comb begin
        prod_next.hi    = sum[WIDTH:1];
        prod_next.lo    = {sum[0], prod_q.lo[WIDTH-1:1]};
        prod_next.guard = prod_q.lo[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else if (accept) begin
            prod_q.hi    <= '0;
            prod_q.lo    <= mplier_i;
            prod_q.guard <= 1'b0;
            mcand_q      <= mcand_i;
        end else if (step) begin
            prod_q <= prod_next;
        end
    end

    assign hi_o = prod_q.hi;
    assign lo_o = prod_q.lo;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_STRAY_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> $stable(mcand_q)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable({hi_o, lo_o})); // R6

    AST_NOP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (prod_q.lo[0] == prod_q.guard)) |=>
        (hi_o == {$past(hi_o[WIDTH-1]), $past(hi_o[WIDTH-1:1])})); // R7

endmodule

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;
    localparam int W = 32;
    localparam longint LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] mcand, mplier;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc   = 0;
    bit     finished = 0;

    logic [2*W-1:0] exp_q[$];
    longint         iss_q[$];
    string          tag_q[$];
    logic [2*W-1:0] last_exp;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    booth_mul_seq #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
        .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
    );

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [2*W-1:0] sprod(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] sa, sb;
        sa = $signed({{W{a[W-1]}}, a});
        sb = $signed({{W{b[W-1]}}, b});
        return sa * sb;
    endfunction

    // Driver: waits for idle, issues a request and records the expected item.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag,
                         input bit stray);
        while (busy) @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        exp_q.push_back(sprod(a, b));
        iss_q.push_back(cyc);
        tag_q.push_back(tag);
        last_exp = sprod(a, b);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
        if (stray) begin
            repeat (3) @(negedge clk);
            mcand = ~a; mplier = b + 32'd5; start = 1'b1;   // R5 stray request
            @(negedge clk);
            start = 1'b0;
        end
        mcand = $urandom; mplier = $urandom;
    endtask

    // Monitor: pops and compares on every done pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 extra done", {hi, lo}, '0);
            end else begin
                logic [2*W-1:0] e;
                longint         t;
                string          g;
                e = exp_q.pop_front();
                t = iss_q.pop_front();
                g = tag_q.pop_front();
                check({hi, lo} == e, g, {hi, lo}, e);
                check((cyc - t) == LAT, "R4 latency", 64'(cyc - t), 64'(LAT));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0; last_exp = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy", {63'b0, busy}, '0);
        check(done == 1'b0, "R1 done", {63'b0, done}, '0);
        check({hi, lo} == '0, "R1 product", {hi, lo}, '0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done} == 2'b00, "R1 after release", {62'b0, busy, done}, '0);

        // Exhaustive small signed pairs, sign-extended (includes 2*7 and 2*-3).
        for (int i = -8; i < 8; i++) begin
            for (int j = -8; j < 8; j++) begin
                logic [W-1:0] a, b;
                a = W'(i); b = W'(j);
                if (j == 0 || j == -1) issue(a, b, "R7 zero/ones multiplier", 1'b0);
                else                   issue(a, b, "R3 small pair", 1'b0);
            end
        end

        // Most negative value corners.
        issue(32'h8000_0000, 32'h8000_0000, "R3 min*min", 1'b0);
        issue(32'h8000_0000, 32'h0000_0001, "R3 min*1", 1'b0);
        issue(32'h8000_0000, 32'hFFFF_FFFF, "R7 min*-1", 1'b0);
        issue(32'h0000_0001, 32'h8000_0000, "R3 1*min", 1'b0);
        issue(32'h7FFF_FFFF, 32'h8000_0000, "R3 max*min", 1'b0);
        issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 max*max", 1'b0);

        // Stray starts during a run must be ignored.
        for (int k = 0; k < 8; k++) issue($urandom, $urandom, "R5 stray start ignored", 1'b1);

        // Random full-width pairs.
        for (int k = 0; k < 200; k++) issue($urandom, $urandom, "R3 random", 1'b0);

        while (busy || exp_q.size() != 0) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check({hi, lo} == last_exp, "R6 hold while idle", {hi, lo}, last_exp);
        check(exp_q.size() == 0, "R5 no pending", 64'(exp_q.size()), '0);
        summary();
    end

endmodule